// File: doc/BRIEF.md
# Serial Configuration Loader

This block is the host-side engine that writes a configuration image into a downstream programmable device through a one-bit serial slave port. A single `start` pulse, together with a byte count, launches a load. The controller first pulses the device's clear line and checks that the device acknowledges the clear through its active-low status line. It then releases the clear line and waits for the status line to go inactive. After that it pulls bytes from a valid/ready stream and shifts each one out, most significant bit first, on a data line that is sampled at the rising edge of a generated serial clock.

Before each byte, the loader checks for the device's error signature: the status line is active while the completion input is still low. If it sees this, it abandons the load. Once the last byte has gone out, the data line is held at one and the serial clock keeps running until the completion input rises. Every wait has a timeout of `TMO_CYC` system clock cycles. The outcome is held on a three-bit result code until the next accepted start. Both device inputs reach the control logic only through multi-flop synchronisers.

Top module: `cfgser_loader`

## Requirements
- R1: After reset, `cfg_clear_n`=1, `cfg_sclk`=0, `cfg_sdata`=1, `busy`=0, `s_ready`=0 and `status`=0 (no result).
- R2: A `start` taken while idle drives `cfg_clear_n` low until the synchronised `cfg_stat_n` reads low. If that does not happen within `TMO_CYC` cycles, the load ends with `status`=2 and `cfg_clear_n` returns high.
- R3: After `cfg_stat_n` reads low, `cfg_clear_n` is released and the loader waits for `cfg_stat_n` high. If that does not happen within `TMO_CYC` cycles, the load ends with `status`=3 and no serial clock edge is issued.
- R4: Each byte is sent as eight rising edges of `cfg_sclk`, MSB first. `cfg_sdata` changes only while `cfg_sclk` is low, and every high and low phase of `cfg_sclk` lasts at least `DIV` cycles.
- R5: Exactly `byte_count` bytes are consumed from the stream, each on a cycle with `s_valid` and `s_ready` both high. Gaps in `s_valid` only stall the serial clock.
- R6: The loader checks for an error before each byte and once before the final completion wait. If `cfg_stat_n` is low while `cfg_complete` is low, the load stops at once with `status`=4 and no further byte is taken.
- R7: After the last byte, `cfg_sdata` stays 1 and `cfg_sclk` keeps toggling until `cfg_complete` reads high. The load then ends with `status`=1.
- R8: If `cfg_complete` does not read high within `TMO_CYC` cycles of the end of data, the load ends with `status`=5.
- R9: A `start` pulse while `busy` is high is ignored. The running load keeps its byte count and `status` stays unchanged until it ends.
- R10: A `byte_count` of zero skips the data phase and goes straight to the completion wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (taken only while idle) |
| byte_count | input | CNT_W | Number of image bytes for the load |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Loader accepts the stream byte this cycle |
| cfg_clear_n | output | 1 | Active-low clear request to the device |
| cfg_sclk | output | 1 | Serial configuration clock |
| cfg_sdata | output | 1 | Serial configuration data |
| cfg_stat_n | input | 1 | Active-low device status (clear acknowledge / error) |
| cfg_complete | input | 1 | Device reports configuration complete |
| busy | output | 1 | A load is in progress |
| status | output | 3 | 0 none, 1 ok, 2 clear-ack timeout, 3 release timeout, 4 error, 5 completion timeout |

## Verification
Several properties are checked on every cycle:
- the data line stays steady while the serial clock is high;
- the stream is only accepted while busy, and never once an error result is recorded;
- the clear line is only driven during a load;
- every finished load leaves a non-zero result;
- the result code is frozen for as long as a load runs.

Some behaviours can only be shown by the bench's scenarios with a device model: the bit order and byte content, the phase widths, each of the four failure paths and its code, byte-count accuracy under stream gaps, the ignored mid-load start, and the zero-length load.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PROG,
      S_REL,
      S_CHECK,
      S_BLO,
      S_BHI,
      S_DWAIT
   } cfg_state_t;

   typedef enum logic [2:0] {
      RES_NONE          = 3'd0,
      RES_OK            = 3'd1,
      RES_ACK_TIMEOUT   = 3'd2,
      RES_REL_TIMEOUT   = 3'd3,
      RES_IMAGE_ERR     = 3'd4,
      RES_CPL_TIMEOUT   = 3'd5
   } cfg_result_t;

endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfgser_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cfgser_sync: WIDTH must be at least 1");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/cfgser_count.sv
module cfgser_count #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic hit
);

   localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   if (LIMIT < 1) begin : g_bad_limit
      $error("cfgser_count: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_single
      assign hit = 1'b1;
   end else begin : g_counter
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (clr)  cnt <= '0;
         else if (!hit) cnt <= cnt + 1'b1;
      end
      assign hit = (cnt == W'(LIMIT - 1));
   end

endmodule

// File: rtl/cfgser_loader.sv
module cfgser_loader
   import cfgser_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV         = 4,
   parameter int TMO_CYC     = 500_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic              s_valid,
   input  logic [BYTE_W-1:0] s_data,
   output logic              s_ready,
   output logic              cfg_clear_n,
   output logic              cfg_sclk,
   output logic              cfg_sdata,
   input  logic              cfg_stat_n,
   input  logic              cfg_complete,
   output logic              busy,
   output logic [2:0]        status
);

   localparam int BIT_W = $clog2(BYTE_W);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("cfgser_loader: CNT_W must be at least 1");
   end
   if (DIV < 1) begin : g_bad_div
      $error("cfgser_loader: DIV must be at least 1");
   end
   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("cfgser_loader: TMO_CYC must be at least 2");
   end

   cfg_state_t        st, st_nxt;
   cfg_result_t       res_q, res_nxt;
   logic [CNT_W-1:0]  rem_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BIT_W-1:0]  idx_q;
   logic              dw_clk_q;

   logic stat_n_s, complete_s, stat_act, err_seen;
   logic ph_hit, tmo_hit, ph_clr, tmo_clr, take;

   // device inputs are asynchronous to clk
   cfgser_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b01)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cfg_complete, cfg_stat_n}),
      .q     ({complete_s, stat_n_s})
   );

   assign stat_act = ~stat_n_s;
   assign err_seen = stat_act & ~complete_s;

   // phase timer: one serial clock half-period
   cfgser_count #(.LIMIT(DIV)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ph_clr),
      .hit   (ph_hit)
   );

   // wait timer: restarts on every state change
   cfgser_count #(.LIMIT(TMO_CYC)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmo_clr),
      .hit   (tmo_hit)
   );

   assign s_ready = (st == S_CHECK) && !err_seen && (rem_q != '0);
   assign take    = s_ready && s_valid;

   always_comb begin
      st_nxt  = st;
      res_nxt = res_q;
      unique case (st)
         S_IDLE: begin
            if (start) begin
               st_nxt  = S_PROG;
               res_nxt = RES_NONE;
            end
         end
         S_PROG: begin
            if (stat_act) begin
               st_nxt = S_REL;
            end else if (tmo_hit) begin
               st_nxt  = S_IDLE;
               res_nxt = RES_ACK_TIMEOUT;
            end
         end
         S_REL: begin
            if (!stat_act) begin
               st_nxt = S_CHECK;
            end else if (tmo_hit) begin
               st_nxt  = S_IDLE;
               res_nxt = RES_REL_TIMEOUT;
            end
         end
         S_CHECK: begin
            if (err_seen) begin
               st_nxt  = S_IDLE;
               res_nxt = RES_IMAGE_ERR;
            end else if (rem_q == '0) begin
               st_nxt = S_DWAIT;
            end else if (s_valid) begin
               st_nxt = S_BLO;
            end
         end
         S_BLO: begin
            if (ph_hit) st_nxt = S_BHI;
         end
         S_BHI: begin
            if (ph_hit) st_nxt = (idx_q == '0) ? S_CHECK : S_BLO;
         end
         S_DWAIT: begin
            if (complete_s) begin
               st_nxt  = S_IDLE;
               res_nxt = RES_OK;
            end else if (tmo_hit) begin
               st_nxt  = S_IDLE;
               res_nxt = RES_CPL_TIMEOUT;
            end
         end
         default: st_nxt = S_IDLE;
      endcase
   end

   assign ph_clr  = ph_hit || (st_nxt != st);
   assign tmo_clr = (st_nxt != st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         res_q    <= RES_NONE;
         rem_q    <= '0;
         sh_q     <= '0;
         idx_q    <= '0;
         dw_clk_q <= 1'b0;
      end else begin
         st    <= st_nxt;
         res_q <= res_nxt;
         if (st == S_IDLE && start) rem_q <= byte_count;
         if (take) begin
            rem_q <= rem_q - 1'b1;
            sh_q  <= s_data;
            idx_q <= '1;
         end
         if (st == S_BHI && ph_hit && idx_q != '0) begin
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            idx_q <= idx_q - 1'b1;
         end
         if (st != S_DWAIT)  dw_clk_q <= 1'b0;
         else if (ph_hit)    dw_clk_q <= ~dw_clk_q;
      end
   end

   assign busy        = (st != S_IDLE);
   assign status      = res_q;
   assign cfg_clear_n = (st != S_PROG);
   assign cfg_sclk    = (st == S_BHI) || (st == S_DWAIT && dw_clk_q);
   assign cfg_sdata   = (st == S_BLO || st == S_BHI) ? sh_q[BYTE_W-1] : 1'b1;

   // R4: data is never changed while the serial clock is high
   p_sdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sclk && $past(cfg_sclk)) |-> $stable(cfg_sdata));

   // R5: stream bytes are only accepted inside a load
   p_ready_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> busy);

   // R2: clear request only during a load
   p_clear_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_clear_n |-> busy);

   // R7: every finished load leaves a result code
   p_result_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (status != 3'd0));

   // R9: result is frozen while a load runs, whatever start does
   p_status_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(status));

   // R6: after an error result nothing more is taken
   p_no_take_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 3'd4) |-> !s_ready);

endmodule

// File: tb/cfgser_loader_bench.sv
module cfgser_loader_bench;

   localparam int CNT_W = 8;
   localparam int DIV   = 2;
   localparam int TMO   = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] byte_count = '0;
   logic             s_valid = 1'b0;
   logic [7:0]       s_data;
   logic             s_ready;
   logic             cfg_clear_n, cfg_sclk, cfg_sdata;
   logic             stat_n_dev = 1'b1;
   logic             cpl_dev = 1'b0;
   logic             busy;
   logic [2:0]       status;

   int errors = 0;
   int checks = 0;

   // device model controls
   bit ack_ok = 1'b1, rel_ok = 1'b1, err_en = 1'b0, cpl_en = 1'b1;
   int err_at = 0, cpl_at = 0;

   // stream source and monitors
   logic [7:0] src_mem [16];
   int  src_idx = 0;
   bit  pend = 1'b0;
   int  rx_bits = 0;
   logic [7:0] rx_sh = '0;
   logic [7:0] rx_mem [16];
   int  exp_bits = 0;
   int  zero_after = 0;
   int  hold_err = 0;
   int  run_len = 0;
   int  min_hi = 999, min_lo = 999;
   logic prev_sclk = 1'b0, prev_sdata = 1'b1;

   assign s_data = src_mem[src_idx[3:0]];

   always #10 clk = ~clk;

   cfgser_loader #(
      .CNT_W   (CNT_W),
      .DIV     (DIV),
      .TMO_CYC (TMO)
   ) u_cfgser_loader (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .byte_count   (byte_count),
      .s_valid      (s_valid),
      .s_data       (s_data),
      .s_ready      (s_ready),
      .cfg_clear_n  (cfg_clear_n),
      .cfg_sclk     (cfg_sclk),
      .cfg_sdata    (cfg_sdata),
      .cfg_stat_n   (stat_n_dev),
      .cfg_complete (cpl_dev),
      .busy         (busy),
      .status       (status)
   );

   // all monitoring and device modelling away from the active edge
   always @(negedge clk) begin
      if (pend) src_idx = src_idx + 1;
      pend = s_valid && s_ready;

      if (cfg_sclk && !prev_sclk) begin
         rx_sh   = {rx_sh[6:0], cfg_sdata};
         rx_bits = rx_bits + 1;
         if (rx_bits <= exp_bits && rx_bits % 8 == 0 && rx_bits <= 128)
            rx_mem[rx_bits/8 - 1] = rx_sh;
         if (rx_bits > exp_bits && !cfg_sdata) zero_after = zero_after + 1;
      end
      if (cfg_sclk && prev_sclk && cfg_sdata !== prev_sdata) hold_err = hold_err + 1;
      if (cfg_sclk == prev_sclk) run_len = run_len + 1;
      else begin
         if (busy) begin
            if (prev_sclk) begin if (run_len < min_hi) min_hi = run_len; end
            else           begin if (run_len < min_lo) min_lo = run_len; end
         end
         run_len = 1;
      end
      prev_sclk  = cfg_sclk;
      prev_sdata = cfg_sdata;

      if (!cfg_clear_n)                    stat_n_dev = ack_ok ? 1'b0 : 1'b1;
      else if (err_en && rx_bits >= err_at) stat_n_dev = 1'b0;
      else if (rel_ok)                      stat_n_dev = 1'b1;

      if (!cfg_clear_n)                          cpl_dev = 1'b0;
      else if (cpl_en && rx_bits >= cpl_at && busy) cpl_dev = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic prep(input int n);
      src_idx = 0; pend = 1'b0; rx_bits = 0; rx_sh = '0;
      exp_bits = n * 8; zero_after = 0; hold_err = 0;
      min_hi = 999; min_lo = 999;
      ack_ok = 1'b1; rel_ok = 1'b1; err_en = 1'b0; cpl_en = 1'b1;
      err_at = 0; cpl_at = n * 8 + 4;
      for (int i = 0; i < 16; i++) rx_mem[i] = 8'h00;
   endtask

   task automatic kick(input int n);
      @(negedge clk);
      byte_count = CNT_W'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(cfg_clear_n == 1'b1, "R1 clear line idle", int'(cfg_clear_n), 1);
      chk(cfg_sclk == 1'b0,    "R1 sclk idle", int'(cfg_sclk), 0);
      chk(cfg_sdata == 1'b1,   "R1 sdata idle", int'(cfg_sdata), 1);
      chk(busy == 1'b0,        "R1 busy idle", int'(busy), 0);
      chk(s_ready == 1'b0,     "R1 ready idle", int'(s_ready), 0);
      chk(status == 3'd0,      "R1 status idle", int'(status), 0);
   endtask

   task automatic t_normal();
      prep(3);
      src_mem[0] = 8'hA5; src_mem[1] = 8'h3C; src_mem[2] = 8'h81;
      s_valid = 1'b0;
      kick(3);
      repeat (40) @(negedge clk);
      s_valid = 1'b1;
      wait_idle();
      chk(status == 3'd1, "R7 load ok code", int'(status), 1);
      chk(rx_mem[0] == 8'hA5, "R4 byte0 msb first", int'(rx_mem[0]), 'hA5);
      chk(rx_mem[1] == 8'h3C, "R4 byte1 msb first", int'(rx_mem[1]), 'h3C);
      chk(rx_mem[2] == 8'h81, "R4 byte2 msb first", int'(rx_mem[2]), 'h81);
      chk(src_idx == 3, "R5 bytes taken with gap", src_idx, 3);
      chk(hold_err == 0, "R4 data stable while sclk high", hold_err, 0);
      chk(min_hi >= DIV, "R4 high phase width", min_hi, DIV);
      chk(min_lo >= DIV, "R4 low phase width", min_lo, DIV);
      chk(rx_bits >= 3*8 + 4, "R7 extra clocks after data", rx_bits, 3*8 + 4);
      chk(zero_after == 0, "R7 data held high after image", zero_after, 0);
   endtask

   task automatic t_busy_start();
      prep(2);
      src_mem[0] = 8'h5A; src_mem[1] = 8'hF0;
      s_valid = 1'b1;
      kick(2);
      repeat (20) @(negedge clk);
      byte_count = CNT_W'(9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(status == 3'd0, "R9 status unchanged by start", int'(status), 0);
      wait_idle();
      chk(src_idx == 2, "R9 byte count kept", src_idx, 2);
      chk(status == 3'd1, "R9 load completes", int'(status), 1);
      chk(rx_mem[1] == 8'hF0, "R9 second byte intact", int'(rx_mem[1]), 'hF0);
   endtask

   task automatic t_ack_timeout();
      prep(2);
      ack_ok = 1'b0;
      kick(2);
      wait_idle();
      chk(status == 3'd2, "R2 clear-ack timeout code", int'(status), 2);
      chk(cfg_clear_n == 1'b1, "R2 clear released", int'(cfg_clear_n), 1);
      chk(rx_bits == 0, "R2 no serial clocks", rx_bits, 0);
   endtask

   task automatic t_rel_timeout();
      prep(2);
      rel_ok = 1'b0;
      kick(2);
      wait_idle();
      chk(status == 3'd3, "R3 release timeout code", int'(status), 3);
      chk(rx_bits == 0, "R3 no serial clocks", rx_bits, 0);
      rel_ok = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_image_err();
      prep(3);
      src_mem[0] = 8'hC3; src_mem[1] = 8'h11; src_mem[2] = 8'h22;
      s_valid = 1'b1;
      err_en = 1'b1; err_at = 7;
      kick(3);
      wait_idle();
      chk(status == 3'd4, "R6 error code", int'(status), 4);
      chk(src_idx == 1, "R6 no byte after error", src_idx, 1);
      chk(rx_bits == 8, "R6 clocks stop after byte", rx_bits, 8);
      err_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_cpl_timeout();
      prep(1);
      src_mem[0] = 8'h96;
      s_valid = 1'b1;
      cpl_en = 1'b0;
      kick(1);
      wait_idle();
      chk(status == 3'd5, "R8 completion timeout code", int'(status), 5);
      chk(rx_mem[0] == 8'h96, "R8 byte still sent", int'(rx_mem[0]), 'h96);
   endtask

   task automatic t_zero();
      prep(0);
      cpl_at = 3;
      s_valid = 1'b1;
      kick(0);
      wait_idle();
      chk(status == 3'd1, "R10 zero-length ok", int'(status), 1);
      chk(src_idx == 0, "R10 nothing taken", src_idx, 0);
      chk(zero_after == 0, "R10 data high during wait", zero_after, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired, all requirements affected");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) src_mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_normal();
      t_busy_start();
      t_ack_timeout();
      t_rel_timeout();
      t_image_err();
      t_cpl_timeout();
      t_zero();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule